// File: doc/BRIEF.md
# MDIO Management Master

This block is the host-side master of a two-wire serial management link to external Ethernet PHY devices. Software programs it through two indirect registers. The control register carries a 5-bit PHY address, a 5-bit register address, a read/write selector and a start bit. The data register holds the value to write, and after a read it holds the value returned by the PHY. A busy flag stays set for the whole transaction and clears by itself when the transaction ends.

When a transaction starts, the block divides the system clock to produce the management clock. It then sends a complete management frame, one bit per clock period: the preamble, the start pattern, the opcode, the two address fields, the turnaround, the data and a trailing idle bit. On a read the master releases the data line from the turnaround onward. It shifts in the 16 bits that the PHY returns and moves them into the data register only when the frame has finished. The bidirectional data pin is split into output, output-enable and input signals. An external pad supplies the pull-up.

Top module: `mdio_master`

## Requirements
- R1: A control write with the start bit set while busy is low latches the PHY address, register address and operation, and busy reads 1 in the following cycle.
- R2: Each frame begins with 32 one bits, followed by the start pattern 0 then 1 (bits 32 and 33 of the frame).
- R3: Bits 34 and 35 carry the opcode: 1,0 for a read (ctl_rd=1) and 0,1 for a write (ctl_rd=0).
- R4: Bits 36 to 40 carry the PHY address and bits 41 to 45 carry the register address, both MSB first. Bits 46 and 47 are the turnaround: a write drives 1 then 0, and a read holds mdio_oe low from bit 46 to the end of the frame.
- R5: On a write, bits 48 to 63 carry the 16-bit value that the data register held at start, MSB first.
- R6: Bit 64 is an idle bit with mdio_oe low. Busy stays high for exactly 65 management clock periods, which is 130*HALF_DIV system clock cycles.
- R7: mdio_out and mdio_oe change only while mdc is low. Read data is sampled on the rising edge of mdc.
- R8: mdc has a period of 2*HALF_DIV system clocks (60 by default). It is low whenever busy is low.
- R9: A start request while busy has no effect on the frame being sent or on its length.
- R10: After a read, dat_q holds the 16 bits sampled in frame bits 48 to 63, MSB first. dat_q does not change while the frame is in progress.
- R11: A data register write while idle updates dat_q in the next cycle. A data register write while busy is ignored, and a write frame does not change dat_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_phy | input | 5 | PHY address field |
| ctl_reg | input | 5 | Register address field |
| ctl_rd | input | 1 | 1 selects a read, 0 a write |
| ctl_start | input | 1 | Start bit of the control write |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | 16 | Data register write value |
| dat_q | output | 16 | Data register contents |
| busy | output | 1 | Transaction in progress |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_in | input | 1 | Data line input value from the pad |

## Verification
The hardest case to reach from the ports is a second start request, or a data register write, that arrives in the middle of a frame. Only a register collision at that moment would corrupt the frame or the returned value. The bench injects both strobes, with conflicting field values, about two hundred cycles into a running frame. It then compares every captured frame bit and the busy length against an undisturbed frame. For reads, a PHY model in the bench drives the line from the second turnaround bit onward. The bench watches dat_q on every cycle of the frame to confirm that the returned value appears only after the idle bit.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int WORD_BITS = 64;

    localparam logic [6:0] IDX_TA   = 7'd46;
    localparam logic [6:0] IDX_DATA = 7'd48;
    localparam logic [6:0] IDX_IDLE = 7'd64;

    typedef enum logic [1:0] {
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10
    } mdio_opc_e;

    // Build the 64 driven bits of a frame; bit 63 is sent first.
    function automatic logic [WORD_BITS-1:0] make_word(
        input logic        is_rd,
        input logic [4:0]  phy,
        input logic [4:0]  regad,
        input logic [15:0] wdata
    );
        mdio_opc_e  opc;
        logic [1:0] ta;
        opc = is_rd ? OPC_READ : OPC_WRITE;
        ta  = is_rd ? 2'b11 : 2'b10;
        return {32'hFFFF_FFFF, 2'b01, opc, phy, regad, ta, wdata};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int HALF_DIV = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } cg_state_t;

    cg_state_t st_d, st_q;
    logic      wrap;

    always_comb begin
        st_d      = st_q;
        wrap      = run && (st_q.cnt == CNT_LAST);
        rise_tick = wrap && !st_q.mdc;
        fall_tick = wrap && st_q.mdc;
        if (!run) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else if (wrap) begin
            st_d.cnt = '0;
            st_d.mdc = !st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc = st_q.mdc;

    // R8: clock parks low one cycle after run drops
    p_park_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);

    // R8: a stretch with run high toggles mdc only on a count wrap
    p_toggle_on_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> $stable(mdc));

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        op_rd,
    input  logic [4:0]  phy,
    input  logic [4:0]  regad,
    input  logic [15:0] wdata,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        mdio_in,
    output logic        busy,
    output logic        done,
    output logic        done_rd,
    output logic [15:0] rdata,
    output logic        mdio_out,
    output logic        mdio_oe
);
    typedef struct packed {
        logic                 busy;
        logic                 rd;
        logic [6:0]           idx;
        logic [WORD_BITS-1:0] word;
        logic [15:0]          rx;
    } fr_state_t;

    fr_state_t st_d, st_q;
    logic      in_data;
    logic      in_word;

    always_comb begin
        st_d    = st_q;
        done    = 1'b0;
        in_word = (st_q.idx < IDX_IDLE);
        in_data = (st_q.idx >= IDX_DATA) && in_word;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.rd   = op_rd;
                st_d.idx  = '0;
                st_d.word = make_word(op_rd, phy, regad, wdata);
            end
        end else begin
            if (rise_tick && st_q.rd && in_data) begin
                st_d.rx = {st_q.rx[14:0], mdio_in};
            end
            if (fall_tick) begin
                if (st_q.idx == IDX_IDLE) begin
                    st_d.busy = 1'b0;
                    done      = 1'b1;
                end else begin
                    st_d.idx = st_q.idx + 7'd1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = st_q.busy;
    assign done_rd  = done && st_q.rd;
    assign rdata    = st_q.rx;
    assign mdio_out = (st_q.busy && in_word) ? st_q.word[~st_q.idx[5:0]] : 1'b1;
    assign mdio_oe  = st_q.busy && in_word && !(st_q.rd && (st_q.idx >= IDX_TA));

    // R1: an idle start is taken on the next edge
    p_start_taken_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R9: a start while busy leaves the frame contents untouched
    p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(st_q.word) && $stable(st_q.rd)));

    // R6: the frame only ends after the idle bit position
    p_end_after_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(st_q.idx) == IDX_IDLE));

    // R6: the bit position advances by at most one per edge
    p_idx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fall_tick) |=> $stable(st_q.idx));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 30
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_we,
    input  logic [4:0]  ctl_phy,
    input  logic [4:0]  ctl_reg,
    input  logic        ctl_rd,
    input  logic        ctl_start,
    input  logic        dat_we,
    input  logic [15:0] dat_wdata,
    output logic [15:0] dat_q,
    output logic        busy,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    typedef struct packed {
        logic [15:0] data;
    } top_state_t;

    top_state_t  st_d, st_q;
    logic        start_req;
    logic        rise_tick;
    logic        fall_tick;
    logic        fr_busy;
    logic        fr_done;
    logic        fr_done_rd;
    logic [15:0] fr_rdata;

    assign start_req = ctl_we && ctl_start;

    mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (fr_busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_req),
        .op_rd     (ctl_rd),
        .phy       (ctl_phy),
        .regad     (ctl_reg),
        .wdata     (st_q.data),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_in   (mdio_in),
        .busy      (fr_busy),
        .done      (fr_done),
        .done_rd   (fr_done_rd),
        .rdata     (fr_rdata),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe)
    );

    always_comb begin
        st_d = st_q;
        if (fr_done_rd) begin
            st_d.data = fr_rdata;
        end else if (dat_we && !fr_busy) begin
            st_d.data = dat_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dat_q = st_q.data;
    assign busy  = fr_busy;

    // R8: no clock activity outside a transaction
    p_mdc_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R7: line value and enable hold while mdc is high
    p_line_steady_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_out) && $stable(mdio_oe)));

    // R10, R11: the data register holds through a frame
    p_data_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(dat_q));

    // R11: a write frame leaves the data register alone at its end
    p_write_keeps_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_done && !fr_done_rd) |=> $stable(dat_q));

endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
    localparam int HALF = 30;
    localparam int FRAME_CYC = 130 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [4:0]  ctl_phy = '0;
    logic [4:0]  ctl_reg = '0;
    logic        ctl_rd = 1'b0;
    logic        ctl_start = 1'b0;
    logic        dat_we = 1'b0;
    logic [15:0] dat_wdata = '0;
    logic [15:0] dat_q;
    logic        busy;
    logic        mdc;
    logic        mdio_out;
    logic        mdio_oe;
    logic        mdio_line;

    int checks = 0;
    int fails = 0;

    // PHY model
    int          bitn = 0;
    logic        phy_rd_en = 1'b0;
    logic [15:0] phy_val = '0;
    logic        cap   [0:64];
    logic        capoe [0:64];

    always #5 clk = ~clk;

    mdio_master #(.HALF_DIV(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_phy(ctl_phy),
        .ctl_reg(ctl_reg), .ctl_rd(ctl_rd), .ctl_start(ctl_start),
        .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_q(dat_q), .busy(busy),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_line)
    );

    always_comb begin
        if (mdio_oe)                                   mdio_line = mdio_out;
        else if (phy_rd_en && bitn == 47)              mdio_line = 1'b0;
        else if (phy_rd_en && bitn >= 48 && bitn <= 63) mdio_line = phy_val[63 - bitn];
        else                                           mdio_line = 1'b1;
    end

    always @(posedge mdc) begin
        if (bitn >= 0 && bitn <= 64) begin
            cap[bitn]   = mdio_line;
            capoe[bitn] = mdio_oe;
        end
    end

    always @(negedge mdc) bitn = bitn + 1;

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_word(input logic rd, input logic [4:0] p,
                                             input logic [4:0] r, input logic [15:0] d);
        logic [63:0] w;
        w[63:32] = '1;
        w[31:30] = 2'b01;
        w[29:28] = rd ? 2'b10 : 2'b01;
        w[27:23] = p;
        w[22:18] = r;
        w[17:16] = rd ? 2'b11 : 2'b10;
        w[15:0]  = d;
        return w;
    endfunction

    // Compare captured bits of one field against the expected word.
    task automatic check_field(input logic [63:0] w, input int lo, input int hi, input string tag);
        logic [63:0] act;
        logic [63:0] exp;
        act = '0;
        exp = '0;
        for (int i = lo; i <= hi; i++) begin
            act = {act[62:0], cap[i]};
            exp = {exp[62:0], w[63 - i]};
        end
        check(act == exp, tag, act, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(busy == 1'b0, "R1 reset busy", busy, 0);
        check(mdc == 1'b0, "R8 reset mdc", mdc, 0);
        check(mdio_oe == 1'b0, "R6 reset oe", mdio_oe, 0);
        check(dat_q == 16'h0, "R10 reset data", dat_q, 0);
    endtask

    // Run one frame. poke injects a start and a data write mid-frame.
    task automatic t_frame(input logic rd, input logic [4:0] p, input logic [4:0] r,
                           input logic [15:0] d, input logic poke);
        int          cnt;
        int          last_rise;
        int          period;
        int          r7bad;
        int          r10bad;
        logic        prev_mdc;
        logic        prev_out;
        logic [15:0] held;
        logic [63:0] w;

        if (!rd) begin
            @(negedge clk);
            dat_we = 1'b1;
            dat_wdata = d;
            @(negedge clk);
            dat_we = 1'b0;
            check(dat_q == d, "R11 idle data write", dat_q, d);
        end
        held = dat_q;
        phy_rd_en = rd;
        phy_val = d;
        bitn = 0;
        ctl_we = 1'b1; ctl_start = 1'b1; ctl_rd = rd; ctl_phy = p; ctl_reg = r;
        @(negedge clk);
        ctl_we = 1'b0; ctl_start = 1'b0;
        check(busy == 1'b1, "R1 busy after start", busy, 1);
        cnt = 1; last_rise = -1; period = -1; r7bad = 0; r10bad = 0;
        prev_mdc = mdc; prev_out = mdio_out;
        forever begin
            if (poke && cnt == 200) begin
                ctl_we = 1'b1; ctl_start = 1'b1; ctl_rd = !rd;
                ctl_phy = ~p; ctl_reg = ~r;
                dat_we = 1'b1; dat_wdata = ~d;
            end
            @(negedge clk);
            ctl_we = 1'b0; ctl_start = 1'b0; dat_we = 1'b0;
            if (!busy) break;
            cnt++;
            if (mdc && !prev_mdc) begin
                if (last_rise >= 0 && period < 0) period = cnt - last_rise;
                last_rise = cnt;
            end
            if (mdc && prev_mdc && mdio_out != prev_out) r7bad++;
            if (dat_q != held) r10bad++;
            prev_mdc = mdc; prev_out = mdio_out;
        end
        check(cnt == FRAME_CYC, poke ? "R9 frame length with poke" : "R6 frame length",
              cnt, FRAME_CYC);
        check(period == 2 * HALF, "R8 mdc period", period, 2 * HALF);
        check(r7bad == 0, "R7 output change while mdc high", r7bad, 0);
        check(r10bad == 0, "R10 data stable during frame", r10bad, 0);
        @(negedge clk);
        check(mdc == 1'b0, "R8 mdc low after frame", mdc, 0);

        w = exp_word(rd, p, r, d);
        check_field(w, 0, 31, "R2 preamble");
        check_field(w, 32, 33, "R2 start pattern");
        check_field(w, 34, 35, "R3 opcode");
        check_field(w, 36, 45, "R4 addresses");
        if (rd) begin
            check(capoe[46] == 1'b0 && capoe[47] == 1'b0 && capoe[55] == 1'b0,
                  "R4 read releases line", {capoe[46], capoe[47], capoe[55]}, 0);
            check(cap[46] == 1'b1 && cap[47] == 1'b0, "R4 read turnaround",
                  {cap[46], cap[47]}, 2'b10);
            check(dat_q == d, "R10 read data loaded", dat_q, d);
        end else begin
            check_field(w, 46, 47, "R4 write turnaround");
            check_field(w, 48, 63, "R5 write data");
            check(dat_q == d, "R11 write frame keeps data", dat_q, d);
        end
        check(capoe[64] == 1'b0 && cap[64] == 1'b1, "R6 idle bit released",
              {capoe[64], cap[64]}, 2'b01);
        if (poke) check(dat_q == d, "R11 busy data write ignored", dat_q, d);
        phy_rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_frame(1'b0, 5'h15, 5'h0A, 16'hC3A5, 1'b0);
        t_frame(1'b1, 5'h1F, 5'h01, 16'h8E71, 1'b0);
        t_frame(1'b0, 5'h00, 5'h1F, 16'h0001, 1'b1);
        t_frame(1'b1, 5'h0B, 5'h12, 16'h5AF0, 1'b1);
        t_frame(1'b1, 5'h01, 5'h00, 16'hFFFF, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule